// File: doc/BRIEF.md
# SPI Slave Register-Access Engine

This block lets an external SPI host read and write 32-bit registers on an internal request/response bus. The host sends a fixed 8-byte header. The header holds a word count, an operation code and a start address, all most significant byte first. For writes, data words follow the header. The engine turns each completed word into one write request on the bus, and a burst advances the address by one word per request.

For a read, the header alone starts one read request. The host then polls with zero bytes. It receives 0x00 until the bus has answered, then a single 0x01 ready marker, then the four data bytes. The SPI pins are oversampled by the system clock in mode 0, MSB first.

Frame position survives chip-select deassertion. A host may therefore split a frame into several chip-select windows. Malformed headers are dropped silently.

Top module: `spi_regbus_slave`

## Requirements
- R1: The header is 8 bytes: bytes 0-1 are a big-endian count field, bytes 2-3 a big-endian opcode (0x0002 single read, 0x0003 single write, 0x0004 burst write), bytes 4-7 the address, MSB first.
- R2: A single write (count field 0) takes bytes 8-11 as one data word, MSB first, and issues exactly one write request at the header address. The next byte is then treated as a new header.
- R3: A burst write with count field C issues C+1 write requests. The words are taken 4 bytes each, MSB first, at addresses base, base+4, base+8 and so on. C = 0 gives exactly one write.
- R4: A burst count field of 0x2000 or more is illegal. Such a header issues no request, and the next bytes are decoded as a fresh header.
- R5: An unknown opcode, or a nonzero count field on a single read or single write, issues no bus request, and the next bytes are decoded as a fresh header.
- R6: A single read issues one read request with write flag 0 at the header address. Each following poll byte returns 0x00 until the response has been captured. Once it has, exactly one 0x01 is returned, then the 4 read data bytes MSB first, after which the frame ends.
- R7: Header, data and poll bytes may be split across separate chip-select windows without losing frame state.
- R8: A bus request keeps valid, write flag, address and write data unchanged until the cycle in which ready is seen.
- R9: MISO is 0 while chip select is high, and it returns 0x00 during every header and write-data byte.
- R10: After reset no bus request is pending, MISO is 0 and the engine expects a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_mosi | input | 1 | SPI data from host |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_miso | output | 1 | SPI data to host |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus accepts request |
| bus_req_write | output | 1 | 1 = write, 0 = read |
| bus_req_addr | output | 32 | Request byte address |
| bus_req_wdata | output | 32 | Write data |
| bus_rsp_valid | input | 1 | Read response valid (one cycle) |
| bus_rsp_rdata | input | 32 | Read response data |

## Verification
The bench aims at the read handshake. In one case the response lands after several polls, and in the other it lands before the first poll. A design that loaded the marker mid-byte, or that repeated it, would return a wrong first data byte or a stale one. Bursts are sent as fragments in separate chip-select windows and against a stalling bus. A design that cleared its counters on chip-select release would lose words or shift the address sequence, and one that let a request change while stalled would corrupt writes. Illegal counts and opcodes are each followed by a good frame. A design that left stray decode state behind would misparse that frame or issue a phantom access.

// File: rtl/spi_regbus_pkg.sv
`timescale 1ns/1ps
// Shared frame states and protocol constants for the SPI register engine.
package spi_regbus_pkg;
    typedef enum logic [2:0] {
        FS_HDR     = 3'd0,
        FS_WDATA   = 3'd1,
        FS_RD_WAIT = 3'd2,
        FS_RD_MARK = 3'd3,
        FS_RD_DATA = 3'd4
    } frame_st_e;

    localparam logic [15:0] OP_READ   = 16'h0002;
    localparam logic [15:0] OP_WRITE  = 16'h0003;
    localparam logic [15:0] OP_BURST  = 16'h0004;
    localparam logic [7:0]  BYTE_IDLE = 8'h00;
    localparam logic [7:0]  BYTE_MARK = 8'h01;
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a group of asynchronous pins.
// Assumes STAGES >= 2; each bit resets to its own value from RST_VAL.
module spi_pin_sync #(
    parameter int              STAGES  = 2,
    parameter int              WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the pin through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], pin_i[g]};
        end
        assign pin_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_byte_engine.sv
`timescale 1ns/1ps
// Mode-0 bit engine: samples MOSI on SCLK rising edges and shifts MISO on
// falling edges. Pin inputs are already synchronized. The transmit byte
// is reloaded from tx_next whenever no byte is in flight (load_ok).
// Releasing chip select discards a partial byte.
module spi_byte_engine (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_s,
    input  logic       mosi_s,
    input  logic       csn_s,
    input  logic [7:0] tx_next,
    output logic       miso,
    output logic [7:0] rx_byte,
    output logic       rx_done,
    output logic       load_ok
);
    logic       sclk_q;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       rise, fall;

    assign rise    = sclk_s & ~sclk_q & ~csn_s;
    assign fall    = ~sclk_s & sclk_q & ~csn_s;
    assign load_ok = (bit_cnt == 3'd0) && !rise;
    assign miso    = csn_s ? 1'b0 : tx_sh[7];

    // Remember the previous SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    // Count bits within the byte; chip-select release restarts the byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     bit_cnt <= 3'd0;
        else if (csn_s) bit_cnt <= 3'd0;
        else if (rise)  bit_cnt <= bit_cnt + 3'd1;
    end

    // Assemble received bits and pulse rx_done on the eighth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            rx_byte <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (rise) begin
                rx_sh <= {rx_sh[5:0], mosi_s};
                if (bit_cnt == 3'd7) begin
                    rx_byte <= {rx_sh, mosi_s};
                    rx_done <= 1'b1;
                end
            end
        end
    end

    // Load the next transmit byte between bytes, shift it on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n)                        tx_sh <= '0;
        else if (load_ok)                  tx_sh <= tx_next;
        else if (fall && bit_cnt != 3'd0)  tx_sh <= {tx_sh[6:0], 1'b0};
    end
endmodule

// File: rtl/spi_frame_ctrl.sv
`timescale 1ns/1ps
// Frame decoder: parses the header, collects write words, issues bus
// requests and runs the read poll/marker/data sequence. State persists
// across chip-select windows. A new request is assumed to be accepted
// before the next word completes.
module spi_frame_ctrl
    import spi_regbus_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    parameter int CMD_W     = 16,
    parameter int MAX_WORDS = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_byte,
    input  logic              rx_done,
    input  logic              load_ok,
    output logic [7:0]        tx_next,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata
);
    localparam int HDR_BITS   = CNT_W + CMD_W + ADDR_W;
    localparam int HDR_BYTES  = HDR_BITS / 8;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int IDX_W      = $clog2(HDR_BYTES);
    localparam logic [IDX_W-1:0]  HDR_LAST  = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0]  WORD_LAST = IDX_W'(WORD_BYTES - 1);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);
    localparam logic [CNT_W-1:0]  CNT_LIMIT = CNT_W'(MAX_WORDS);

    frame_st_e               state;
    logic [IDX_W-1:0]        byte_idx;
    logic [HDR_BITS-9:0]     hdr_sh;
    logic [DATA_W-9:0]       word_sh;
    logic [CNT_W-1:0]        words_left;
    logic [ADDR_W-1:0]       addr_cur;
    logic [DATA_W-1:0]       rd_hold;
    logic                    rsp_got;

    logic [HDR_BITS-1:0]     hdr_full;
    logic [CNT_W-1:0]        hdr_cnt;
    logic [CMD_W-1:0]        hdr_cmd;
    logic [ADDR_W-1:0]       hdr_addr;
    logic [DATA_W-1:0]       word_full;

    assign hdr_full  = {hdr_sh, rx_byte};
    assign hdr_cnt   = hdr_full[HDR_BITS-1 -: CNT_W];
    assign hdr_cmd   = hdr_full[ADDR_W +: CMD_W];
    assign hdr_addr  = hdr_full[ADDR_W-1:0];
    assign word_full = {word_sh, rx_byte};

    // Choose the byte the engine sends next from the frame position.
    always_comb begin
        unique case (state)
            FS_RD_WAIT: tx_next = rsp_got ? BYTE_MARK : BYTE_IDLE;
            FS_RD_MARK: tx_next = BYTE_MARK;
            FS_RD_DATA: tx_next = rd_hold[(DATA_W-1) - 8*int'(byte_idx) -: 8];
            default:    tx_next = BYTE_IDLE;
        endcase
    end

    // Frame sequencing, request issue and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= FS_HDR;
            byte_idx   <= '0;
            hdr_sh     <= '0;
            word_sh    <= '0;
            words_left <= '0;
            addr_cur   <= '0;
            rd_hold    <= '0;
            rsp_got    <= 1'b0;
            req_valid  <= 1'b0;
            req_write  <= 1'b0;
            req_addr   <= '0;
            req_wdata  <= '0;
        end else begin
            if (req_valid && req_ready) req_valid <= 1'b0;
            unique case (state)
                FS_HDR: if (rx_done) begin
                    if (byte_idx == HDR_LAST) begin
                        byte_idx <= '0;
                        if (hdr_cmd == CMD_W'(OP_READ) && hdr_cnt == '0) begin
                            req_valid <= 1'b1;
                            req_write <= 1'b0;
                            req_addr  <= hdr_addr;
                            rsp_got   <= 1'b0;
                            state     <= FS_RD_WAIT;
                        end else if (hdr_cmd == CMD_W'(OP_WRITE) && hdr_cnt == '0) begin
                            words_left <= '0;
                            addr_cur   <= hdr_addr;
                            state      <= FS_WDATA;
                        end else if (hdr_cmd == CMD_W'(OP_BURST) && hdr_cnt < CNT_LIMIT) begin
                            words_left <= hdr_cnt;
                            addr_cur   <= hdr_addr;
                            state      <= FS_WDATA;
                        end
                    end else begin
                        hdr_sh   <= {hdr_sh[HDR_BITS-17:0], rx_byte};
                        byte_idx <= byte_idx + 1'b1;
                    end
                end
                FS_WDATA: if (rx_done) begin
                    if (byte_idx == WORD_LAST) begin
                        byte_idx  <= '0;
                        req_valid <= 1'b1;
                        req_write <= 1'b1;
                        req_addr  <= addr_cur;
                        req_wdata <= word_full;
                        addr_cur  <= addr_cur + ADDR_STEP;
                        if (words_left == '0) state <= FS_HDR;
                        else                  words_left <= words_left - 1'b1;
                    end else begin
                        word_sh  <= {word_sh[DATA_W-17:0], rx_byte};
                        byte_idx <= byte_idx + 1'b1;
                    end
                end
                FS_RD_WAIT: begin
                    if (rsp_valid && !rsp_got) begin
                        rd_hold <= rsp_rdata;
                        rsp_got <= 1'b1;
                    end
                    if (rsp_got && load_ok) state <= FS_RD_MARK;
                end
                FS_RD_MARK: if (rx_done) begin
                    byte_idx <= '0;
                    state    <= FS_RD_DATA;
                end
                FS_RD_DATA: if (rx_done) begin
                    if (byte_idx == WORD_LAST) begin
                        byte_idx <= '0;
                        state    <= FS_HDR;
                    end else begin
                        byte_idx <= byte_idx + 1'b1;
                    end
                end
                default: state <= FS_HDR;
            endcase
        end
    end
endmodule

// File: rtl/spi_regbus_slave.sv
`timescale 1ns/1ps
// SPI slave to register-bus bridge. Synchronizes the SPI pins, serializes
// bytes, and decodes framed register reads and writes. Assumes the system
// clock runs at least 8x SCLK.
module spi_regbus_slave #(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int MAX_WORDS   = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_csn,
    output logic              spi_miso,
    output logic              bus_req_valid,
    input  logic              bus_req_ready,
    output logic              bus_req_write,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_rsp_valid,
    input  logic [DATA_W-1:0] bus_rsp_rdata
);
    logic [2:0] pins_s;
    logic       sclk_s, mosi_s, csn_s;
    logic [7:0] rx_byte, tx_next;
    logic       rx_done, load_ok;

    spi_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({spi_csn, spi_mosi, spi_sclk}),
        .pin_o (pins_s)
    );
    assign {csn_s, mosi_s, sclk_s} = pins_s;

    spi_byte_engine u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .mosi_s  (mosi_s),
        .csn_s   (csn_s),
        .tx_next (tx_next),
        .miso    (spi_miso),
        .rx_byte (rx_byte),
        .rx_done (rx_done),
        .load_ok (load_ok)
    );

    spi_frame_ctrl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (16),
        .CMD_W     (16),
        .MAX_WORDS (MAX_WORDS)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_byte   (rx_byte),
        .rx_done   (rx_done),
        .load_ok   (load_ok),
        .tx_next   (tx_next),
        .req_valid (bus_req_valid),
        .req_ready (bus_req_ready),
        .req_write (bus_req_write),
        .req_addr  (bus_req_addr),
        .req_wdata (bus_req_wdata),
        .rsp_valid (bus_rsp_valid),
        .rsp_rdata (bus_rsp_rdata)
    );
endmodule

// File: rtl/spi_regbus_slave_chk.sv
`timescale 1ns/1ps
// Protocol checker for spi_regbus_slave, attached by bind.
module spi_regbus_slave_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn_s,
    input logic              spi_miso,
    input logic              rx_done,
    input logic              bus_req_valid,
    input logic              bus_req_ready,
    input logic              bus_req_write,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic [DATA_W-1:0] bus_req_wdata
);
    // R8: a stalled request holds all of its fields
    a_r8_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_write)
            && $stable(bus_req_addr) && $stable(bus_req_wdata));

    // R9: no drive on MISO while deselected
    a_r9_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |-> !spi_miso);

    // R1: each received byte is reported once
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R2: requests only start right after a byte completes
    a_r2_req_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_valid) |-> $past(rx_done));

    // R10: nothing pending in the first cycle out of reset
    a_r10_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !bus_req_valid);
endmodule

bind spi_regbus_slave spi_regbus_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .csn_s         (csn_s),
    .spi_miso      (spi_miso),
    .rx_done       (rx_done),
    .bus_req_valid (bus_req_valid),
    .bus_req_ready (bus_req_ready),
    .bus_req_write (bus_req_write),
    .bus_req_addr  (bus_req_addr),
    .bus_req_wdata (bus_req_wdata)
);

// File: tb/sim_spi_regbus_slave.sv
`timescale 1ns/1ps
module sim_spi_regbus_slave;
    localparam int HP_NS = 60;

    typedef struct packed {
        logic [15:0] cnt;
        logic [15:0] cmd;
        logic [31:0] addr;
        logic [31:0] data;
        logic [7:0]  lat;
        logic [1:0]  kind;   // 0 write, 1 read, 2 rejected
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 16'h0003, 32'h1000_0040, 32'hDEAD_BEEF, 8'd0,   2'd0},
        '{16'h0000, 16'h0002, 32'h1000_0040, 32'h0,         8'd200, 2'd1},
        '{16'h0000, 16'h0003, 32'hFFFF_FFFC, 32'h0123_4567, 8'd0,   2'd0},
        '{16'h0000, 16'h0005, 32'h0000_0100, 32'h0,         8'd0,   2'd2},
        '{16'h0001, 16'h0002, 32'h0000_0200, 32'h0,         8'd0,   2'd2},
        '{16'h0100, 16'h0003, 32'h0000_0300, 32'h0,         8'd0,   2'd2},
        '{16'h2000, 16'h0004, 32'h0000_0400, 32'h0,         8'd0,   2'd2},
        '{16'h0000, 16'h0002, 32'h0000_0008, 32'h0,         8'd2,   2'd1},
        '{16'hFFFF, 16'h0004, 32'h0000_0600, 32'h0,         8'd0,   2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0, spi_mosi = 1'b0, spi_csn = 1'b1;
    logic        spi_miso;
    logic        bus_req_valid, bus_req_write;
    logic        bus_req_ready = 1'b0;
    logic [31:0] bus_req_addr, bus_req_wdata;
    logic        bus_rsp_valid = 1'b0;
    logic [31:0] bus_rsp_rdata = '0;

    int n_chk = 0, n_err = 0;
    int stall_cfg = 0, rd_lat = 2, wcnt = 0, rsp_cd = -1;
    logic [31:0] rsp_addr;
    logic [31:0] lg_addr [64];
    logic [31:0] lg_data [64];
    logic        lg_wr   [64];
    int          lg_n = 0;

    spi_regbus_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_csn(spi_csn), .spi_miso(spi_miso), .bus_req_valid(bus_req_valid),
        .bus_req_ready(bus_req_ready), .bus_req_write(bus_req_write),
        .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] rd_fn(input logic [31:0] a);
        return {a[15:0] ^ 16'hC35A, a[31:16] ^ 16'h7E24};
    endfunction

    // Bus responder, acting on falling edges.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_req_ready = 1'b0; bus_rsp_valid = 1'b0; wcnt = 0; rsp_cd = -1;
        end else begin
            bus_rsp_valid = 1'b0;
            if (rsp_cd > 0) rsp_cd--;
            else if (rsp_cd == 0) begin
                bus_rsp_valid = 1'b1; bus_rsp_rdata = rd_fn(rsp_addr); rsp_cd = -1;
            end
            if (bus_req_ready) bus_req_ready = 1'b0;
            else if (bus_req_valid) begin
                if (wcnt >= stall_cfg) begin
                    bus_req_ready = 1'b1; wcnt = 0;
                    lg_addr[lg_n % 64] = bus_req_addr;
                    lg_data[lg_n % 64] = bus_req_wdata;
                    lg_wr[lg_n % 64]   = bus_req_write;
                    lg_n++;
                    if (!bus_req_write) begin rsp_cd = rd_lat; rsp_addr = bus_req_addr; end
                end else wcnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            #(HP_NS);
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            #(HP_NS);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic cs_low();
        spi_csn = 1'b0; #(HP_NS);
    endtask

    task automatic cs_high();
        #(HP_NS); spi_csn = 1'b1; #(2*HP_NS);
    endtask

    task automatic send_hdr(input logic [15:0] c, input logic [15:0] op, input logic [31:0] a,
                            output logic [7:0] orx);
        logic [63:0] h;
        logic [7:0]  r;
        h = {c, op, a};
        orx = 8'h00;
        for (int b = 0; b < 8; b++) begin
            xfer(h[63 - 8*b -: 8], r);
            orx |= r;
        end
    endtask

    task automatic send_word(input logic [31:0] w, output logic [7:0] orx);
        logic [7:0] r;
        orx = 8'h00;
        for (int b = 0; b < 4; b++) begin
            xfer(w[31 - 8*b -: 8], r);
            orx |= r;
        end
    endtask

    task automatic poll(output logic [7:0] r);
        cs_low(); xfer(8'h00, r); cs_high();
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0]  orx, r;
        logic [31:0] rd;
        int          base, npre;
        bit          found;

        wait_clk(5);
        // R10: idle after reset
        chk(bus_req_valid === 1'b0, "R10 req idle in reset", {31'b0, bus_req_valid}, 0);
        rst_n = 1'b1;
        wait_clk(3);
        chk(bus_req_valid === 1'b0 && spi_miso === 1'b0, "R10 idle after reset",
            {30'b0, bus_req_valid, spi_miso}, 0);
        cs_low();
        chk(spi_miso === 1'b0, "R10 first MISO bit after select", {31'b0, spi_miso}, 0);
        cs_high();

        // Table-driven frames: R1 R2 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            base = lg_n;
            rd_lat = int'(VECS[v].lat);
            cs_low();
            send_hdr(VECS[v].cnt, VECS[v].cmd, VECS[v].addr, orx);
            if (VECS[v].kind == 2'd0) send_word(VECS[v].data, r);
            else r = 8'h00;
            cs_high();
            chk((orx | r) == 8'h00, "R9 MISO zero in header/data", {24'b0, orx | r}, 0);
            if (VECS[v].kind == 2'd0) begin
                wait_clk(10);
                chk(lg_n == base + 1, "R2 one write issued", lg_n - base, 1);
                chk(lg_wr[base % 64] == 1'b1 && lg_addr[base % 64] == VECS[v].addr,
                    "R1 write address", lg_addr[base % 64], VECS[v].addr);
                chk(lg_data[base % 64] == VECS[v].data, "R2 write data", lg_data[base % 64], VECS[v].data);
            end else if (VECS[v].kind == 2'd1) begin
                npre = 0; found = 1'b0;
                for (int p = 0; p < 40 && !found; p++) begin
                    poll(r);
                    if (r == 8'h01) found = 1'b1;
                    else begin
                        npre++;
                        chk(r == 8'h00, "R6 not-ready byte", {24'b0, r}, 0);
                    end
                end
                chk(found, "R6 marker seen", {31'b0, found}, 1);
                if (VECS[v].lat > 8'd50)
                    chk(npre >= 1, "R6 zero polls before late data", npre, 1);
                else
                    chk(npre == 0, "R6 marker on first poll", npre, 0);
                for (int k = 0; k < 4; k++) begin
                    poll(r);
                    rd[31 - 8*k -: 8] = r;
                end
                chk(rd == rd_fn(VECS[v].addr), "R6 read data MSB first", rd, rd_fn(VECS[v].addr));
                chk(lg_n == base + 1 && lg_wr[base % 64] == 1'b0 && lg_addr[base % 64] == VECS[v].addr,
                    "R6 read request", lg_addr[base % 64], VECS[v].addr);
            end else begin
                wait_clk(30);
                chk(lg_n == base, (VECS[v].cmd == 16'h0004) ? "R4 illegal burst dropped"
                                                             : "R5 bad header dropped",
                    lg_n - base, 0);
            end
        end

        // R3 R7 R8: burst of 3 split across windows, stalled bus
        stall_cfg = 3;
        base = lg_n;
        cs_low();
        for (int b = 0; b < 8; b++) begin
            if (b == 4) begin
                cs_high();
                chk(spi_miso === 1'b0, "R9 MISO low while deselected", {31'b0, spi_miso}, 0);
                cs_low();
            end
            xfer(b == 1 ? 8'h02 : (b == 3 ? 8'h04 : (b == 4 ? 8'h20 : (b == 7 ? 8'hF0 : 8'h00))), r);
        end
        cs_high();
        for (int w = 0; w < 3; w++) begin
            cs_low(); send_word(32'hA000_0000 + w * 32'h0101_0101, r); cs_high();
        end
        wait_clk(20);
        chk(lg_n == base + 3, "R3 burst issues count+1 writes", lg_n - base, 3);
        for (int w = 0; w < 3; w++) begin
            chk(lg_addr[(base + w) % 64] == 32'h2000_00F0 + 4 * w, "R3 burst address step",
                lg_addr[(base + w) % 64], 32'h2000_00F0 + 4 * w);
            chk(lg_data[(base + w) % 64] == 32'hA000_0000 + w * 32'h0101_0101, "R7 burst data kept",
                lg_data[(base + w) % 64], 32'hA000_0000 + w * 32'h0101_0101);
        end
        stall_cfg = 0;

        // R3: burst count field 0 writes one word, then a new header follows
        base = lg_n;
        cs_low(); send_hdr(16'h0000, 16'h0004, 32'h0000_0500, orx); send_word(32'h5555_AAAA, r); cs_high();
        cs_low(); send_hdr(16'h0000, 16'h0003, 32'h0000_0700, orx); send_word(32'h1357_9BDF, r); cs_high();
        wait_clk(10);
        chk(lg_n == base + 2, "R3 single-word burst then new frame", lg_n - base, 2);
        chk(lg_addr[base % 64] == 32'h500 && lg_addr[(base + 1) % 64] == 32'h700,
            "R3 single-word burst address", lg_addr[(base + 1) % 64], 32'h700);
        chk(lg_data[(base + 1) % 64] == 32'h1357_9BDF, "R2 write after burst",
            lg_data[(base + 1) % 64], 32'h1357_9BDF);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule